// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block connects a processor's one-cycle memory request port to an asynchronous SRAM bus. On that bus the low eight lines carry the low address byte first and the data byte second. A separate group of lines carries the high address byte, and three control lines complete the bus: an address latch enable and active-low read and write strobes. Each accepted request is classified as internal or external. An external request runs an address phase, then a strobe phase stretched by wait states, then a one-cycle ready pulse back to the processor.

Above the internal boundary the external space is divided into a lower sector and an upper sector. A 3-bit limit setting places the boundary between them, and each sector has its own 2-bit wait count. Internal accesses still show the address, the data and the latch pulse on the bus, but the strobes stay inactive. When the interface is disabled, every request completes at once and the bus stays quiet. A count input selects how many high address lines the block drives.

Top module: `xbus_ctrl`

## Requirements
- R1: While reset is held and right after it, `bus_ale` is 0, `bus_rd_n` and `bus_wr_n` are 1, `bus_ad_oe` is 0 and `rsp_ready` is 0.
- R2: With the interface enabled, an address at or below 0x10FF is internal. It produces one latch pulse and one data cycle with both strobes held high, and `rsp_ready` rises in the third cycle after acceptance.
- R3: An enabled access raises `bus_ale` for exactly one cycle. In that cycle `bus_ad_out` carries address bits 7..0 and `bus_ad_oe` is 1. `bus_ale` stays low for the whole strobe phase.
- R4: An external address lies in the upper sector when the limit L is nonzero and address bits 15..13 are at least L, which puts the boundary at L×0x2000. With L = 0 the whole external space uses the lower-sector wait count.
- R5: For an external access, the active strobe stays low for 1 + W consecutive cycles, where W (0..3) is the wait count of the access's sector. The two strobes are never low together.
- R6: During an external write, `bus_wr_n` is low, `bus_ad_oe` is 1 and `bus_ad_out` equals the write data.
- R7: During an external read, `bus_ad_oe` is 0 while `bus_rd_n` is low. `rsp_rdata` takes the value on `bus_ad_in` in the last strobe-low cycle.
- R8: `rsp_ready` is a one-cycle pulse in the cycle right after the last strobe-active cycle, which is 2 + W + 1 cycles after acceptance for an external access.
- R9: A request is accepted only in the idle state. A request held high through a transfer, including its ready cycle, does not start a second access.
- R10: With `cfg_en` at 0, a request gives `rsp_ready` in the next cycle with no latch pulse, no strobe, `bus_ad_oe` at 0 and `bus_ha_oe` all zero.
- R11: `bus_ha_oe[i]` is 1 exactly when `cfg_en` is 1 and i < `cfg_hi_bits`. During the latch pulse `bus_ha_out` equals address bits 15..8.
- R12: The classification and the wait count are captured at acceptance. Changing the wait settings during an access does not change that access's strobe length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, sampled only when idle |
| req_addr | input | 16 | Request address |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Write data |
| rsp_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Data captured on the last external read strobe cycle |
| cfg_en | input | 1 | Interface enable |
| cfg_sector_lim | input | 3 | Sector boundary (0 = single sector) |
| cfg_wait_lo | input | 2 | Wait count of the lower sector |
| cfg_wait_hi | input | 2 | Wait count of the upper sector |
| cfg_hi_bits | input | 4 | Number of high address lines driven (0..8) |
| bus_ad_out | output | 8 | Multiplexed address/data out |
| bus_ad_in | input | 8 | Multiplexed data in |
| bus_ad_oe | output | 1 | Drive enable of the multiplexed lines |
| bus_ha_out | output | 8 | High address byte |
| bus_ha_oe | output | 8 | Per-line drive enable of the high address |
| bus_ale | output | 1 | Address latch enable |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |

## Verification
Two events can fall in the same cycle: the ready pulse that closes an access, and a fresh request from the processor. The bench holds `req_valid` high from acceptance through the ready cycle and one cycle past it. It then checks that only one latch pulse and one strobe window appear, and that no latch pulse follows in the next cycles. A second case changes the wait setting in the cycle after acceptance, while the strobe phase is being set up. Only the strobe length captured at acceptance may appear.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ADDR = 2'd1,
      PH_STRB = 2'd2,
      PH_DONE = 2'd3
   } xbus_phase_e;
endpackage

// File: rtl/xbus_decode.sv
module xbus_decode #(
   parameter int          AW       = 16,
   parameter int          LIM_W    = 3,
   parameter int          WS_W     = 2,
   parameter logic [15:0] INT_TOP  = 16'h10FF,
   parameter bit          SECTORED = 1'b1
) (
   input  logic [AW-1:0]    addr,
   input  logic             en,
   input  logic [LIM_W-1:0] limit,
   input  logic [WS_W-1:0]  wait_lo,
   input  logic [WS_W-1:0]  wait_hi,
   output logic             is_ext,
   output logic             in_upper,
   output logic [WS_W-1:0]  waits
);
   localparam logic [AW-1:0] TOP = AW'(INT_TOP);

   assign is_ext = en && (addr > TOP);

   generate
      if (SECTORED) begin : g_two_sectors
         logic [LIM_W-1:0] region;
         assign region   = addr[AW-1 -: LIM_W];
         assign in_upper = is_ext && (limit != '0) && (region >= limit);
      end else begin : g_one_sector
         assign in_upper = 1'b0;
      end
   endgenerate

   assign waits = in_upper ? wait_hi : wait_lo;
endmodule

// File: rtl/xbus_hidrv.sv
module xbus_hidrv #(
   parameter int HI_W = 8,
   parameter int HB_W = 4
) (
   input  logic            en,
   input  logic [HB_W-1:0] count,
   output logic [HI_W-1:0] oe
);
   generate
      for (genvar i = 0; i < HI_W; i++) begin : g_line
         assign oe[i] = en && (count > HB_W'(i));
      end
   endgenerate
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
   import xbus_pkg::*;
#(
   parameter int AW   = 16,
   parameter int DW   = 8,
   parameter int WS_W = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   input  logic [AW-1:0]   req_addr,
   input  logic            req_we,
   input  logic [DW-1:0]   req_wdata,
   input  logic            cfg_en,
   input  logic            dec_ext,
   input  logic [WS_W-1:0] dec_waits,
   input  logic [DW-1:0]   ad_in,
   output xbus_phase_e     phase,
   output logic            ale,
   output logic [DW-1:0]   ad_out,
   output logic            ad_oe,
   output logic [AW-DW-1:0] ha_out,
   output logic            rd_n,
   output logic            wr_n,
   output logic            rsp_ready,
   output logic [DW-1:0]   rsp_rdata
);
   xbus_phase_e     phase_q;
   logic [WS_W-1:0] cnt_q;
   logic [AW-1:0]   addr_q;
   logic [DW-1:0]   wd_q;
   logic            we_q;
   logic            ext_q;
   logic            act_q;
   logic            accept;
   logic            strobe_on;

   assign accept    = (phase_q == PH_IDLE) && req_valid;
   assign strobe_on = (phase_q == PH_STRB) && ext_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q   <= PH_IDLE;
         cnt_q     <= '0;
         addr_q    <= '0;
         wd_q      <= '0;
         we_q      <= 1'b0;
         ext_q     <= 1'b0;
         act_q     <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         unique case (phase_q)
            PH_IDLE: begin
               if (accept) begin
                  addr_q  <= req_addr;
                  wd_q    <= req_wdata;
                  we_q    <= req_we;
                  ext_q   <= dec_ext;
                  act_q   <= cfg_en;
                  cnt_q   <= dec_ext ? dec_waits : '0;
                  phase_q <= cfg_en ? PH_ADDR : PH_DONE;
               end
            end
            PH_ADDR: phase_q <= PH_STRB;
            PH_STRB: begin
               if (cnt_q == '0) begin
                  phase_q <= PH_DONE;
                  if (ext_q && !we_q) rsp_rdata <= ad_in;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            PH_DONE: phase_q <= PH_IDLE;
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign phase     = phase_q;
   assign ale       = (phase_q == PH_ADDR);
   assign ad_out    = (phase_q == PH_ADDR) ? addr_q[DW-1:0] : wd_q;
   assign ad_oe     = act_q && ((phase_q == PH_ADDR) ||
                      (we_q && (phase_q == PH_STRB || phase_q == PH_DONE)));
   assign ha_out    = addr_q[AW-1:DW];
   assign rd_n      = !(strobe_on && !we_q);
   assign wr_n      = !(strobe_on && we_q);
   assign rsp_ready = (phase_q == PH_DONE);
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
   import xbus_pkg::*;
#(
   parameter int          ADDR_W   = 16,
   parameter int          DATA_W   = 8,
   parameter int          LIM_W    = 3,
   parameter int          WS_W     = 2,
   parameter logic [15:0] INT_TOP  = 16'h10FF,
   parameter bit          SECTORED = 1'b1,
   localparam int         HI_W     = ADDR_W - DATA_W,
   localparam int         HB_W     = $clog2(HI_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_we,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_ready,
   output logic [DATA_W-1:0] rsp_rdata,
   input  logic              cfg_en,
   input  logic [LIM_W-1:0]  cfg_sector_lim,
   input  logic [WS_W-1:0]   cfg_wait_lo,
   input  logic [WS_W-1:0]   cfg_wait_hi,
   input  logic [HB_W-1:0]   cfg_hi_bits,
   output logic [DATA_W-1:0] bus_ad_out,
   input  logic [DATA_W-1:0] bus_ad_in,
   output logic              bus_ad_oe,
   output logic [HI_W-1:0]   bus_ha_out,
   output logic [HI_W-1:0]   bus_ha_oe,
   output logic              bus_ale,
   output logic              bus_rd_n,
   output logic              bus_wr_n
);
   generate
      if (ADDR_W <= DATA_W) begin : g_bad_widths
         $error("xbus_ctrl: ADDR_W must exceed DATA_W");
      end
      if (LIM_W < 1 || LIM_W > ADDR_W) begin : g_bad_lim
         $error("xbus_ctrl: LIM_W out of range");
      end
      if (ADDR_W > 16) begin : g_bad_top
         $error("xbus_ctrl: INT_TOP is sized for at most 16 address bits");
      end
   endgenerate

   logic            dec_ext;
   logic            dec_upper;
   logic [WS_W-1:0] dec_waits;
   xbus_phase_e     phase;

   xbus_decode #(
      .AW(ADDR_W), .LIM_W(LIM_W), .WS_W(WS_W),
      .INT_TOP(INT_TOP), .SECTORED(SECTORED)
   ) u_decode (
      .addr     (req_addr),
      .en       (cfg_en),
      .limit    (cfg_sector_lim),
      .wait_lo  (cfg_wait_lo),
      .wait_hi  (cfg_wait_hi),
      .is_ext   (dec_ext),
      .in_upper (dec_upper),
      .waits    (dec_waits)
   );

   xbus_hidrv #(.HI_W(HI_W), .HB_W(HB_W)) u_hidrv (
      .en    (cfg_en),
      .count (cfg_hi_bits),
      .oe    (bus_ha_oe)
   );

   xbus_seq #(.AW(ADDR_W), .DW(DATA_W), .WS_W(WS_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_addr  (req_addr),
      .req_we    (req_we),
      .req_wdata (req_wdata),
      .cfg_en    (cfg_en),
      .dec_ext   (dec_ext),
      .dec_waits (dec_waits),
      .ad_in     (bus_ad_in),
      .phase     (phase),
      .ale       (bus_ale),
      .ad_out    (bus_ad_out),
      .ad_oe     (bus_ad_oe),
      .ha_out    (bus_ha_out),
      .rd_n      (bus_rd_n),
      .wr_n      (bus_wr_n),
      .rsp_ready (rsp_ready),
      .rsp_rdata (rsp_rdata)
   );
endmodule

// File: rtl/xbus_ctrl_chk.sv
module xbus_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic ale,
   input logic ad_oe,
   input logic rd_n,
   input logic wr_n,
   input logic rsp_ready
);
   assert_one_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(!rd_n && !wr_n));

   assert_ale_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ale |=> !ale);

   assert_ale_drives_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ale |-> ad_oe);

   assert_ale_no_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ale |-> (rd_n && wr_n));

   assert_read_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |-> !ad_oe);

   assert_write_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_n |-> ad_oe);

   assert_ready_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_ready |=> !rsp_ready);

   assert_ready_after_rd_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_n) |-> rsp_ready);

   assert_ready_after_wr_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_n) |-> rsp_ready);
endmodule

bind xbus_ctrl xbus_ctrl_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ale       (bus_ale),
   .ad_oe     (bus_ad_oe),
   .rd_n      (bus_rd_n),
   .wr_n      (bus_wr_n),
   .rsp_ready (rsp_ready)
);

// File: tb/xbus_ctrl_test.sv
module xbus_ctrl_test;
   localparam int HALF = 4;

   typedef struct packed {
      logic [15:0] addr;
      logic        we;
      logic [2:0]  lim;
      logic [1:0]  wlo;
      logic [1:0]  whi;
      logic [3:0]  strb;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VECS [NV] = '{
      '{16'h0100, 1'b0, 3'd0, 2'd2, 2'd3, 4'd0},
      '{16'h10FF, 1'b1, 3'd0, 2'd2, 2'd3, 4'd0},
      '{16'h1100, 1'b0, 3'd0, 2'd2, 2'd3, 4'd3},
      '{16'hFFFF, 1'b1, 3'd0, 2'd1, 2'd3, 4'd2},
      '{16'h3FFF, 1'b0, 3'd2, 2'd0, 2'd3, 4'd1},
      '{16'h4000, 1'b0, 3'd2, 2'd0, 2'd3, 4'd4},
      '{16'hE000, 1'b1, 3'd7, 2'd1, 2'd2, 4'd3},
      '{16'hDFFF, 1'b1, 3'd7, 2'd1, 2'd2, 4'd2},
      '{16'h2000, 1'b0, 3'd1, 2'd3, 2'd0, 4'd1},
      '{16'h1FFF, 1'b0, 3'd1, 2'd3, 2'd0, 4'd4},
      '{16'h1234, 1'b1, 3'd3, 2'd2, 2'd1, 4'd3}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [15:0] req_addr = '0;
   logic       req_we = 1'b0;
   logic [7:0] req_wdata = '0;
   logic       rsp_ready;
   logic [7:0] rsp_rdata;
   logic       cfg_en = 1'b0;
   logic [2:0] cfg_sector_lim = '0;
   logic [1:0] cfg_wait_lo = '0;
   logic [1:0] cfg_wait_hi = '0;
   logic [3:0] cfg_hi_bits = '0;
   logic [7:0] bus_ad_out;
   logic [7:0] bus_ad_in = '0;
   logic       bus_ad_oe;
   logic [7:0] bus_ha_out;
   logic [7:0] bus_ha_oe;
   logic       bus_ale;
   logic       bus_rd_n;
   logic       bus_wr_n;

   int n_chk = 0;
   int n_bad = 0;

   int         o_lat, o_ale, o_rd, o_wr, o_wbad, o_rbad, o_oe, o_post, o_haoe;
   logic [7:0] o_aaddr, o_ahi;

   always #(HALF) clk = ~clk;

   xbus_ctrl uut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_addr(req_addr), .req_we(req_we),
      .req_wdata(req_wdata), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
      .cfg_en(cfg_en), .cfg_sector_lim(cfg_sector_lim),
      .cfg_wait_lo(cfg_wait_lo), .cfg_wait_hi(cfg_wait_hi),
      .cfg_hi_bits(cfg_hi_bits),
      .bus_ad_out(bus_ad_out), .bus_ad_in(bus_ad_in), .bus_ad_oe(bus_ad_oe),
      .bus_ha_out(bus_ha_out), .bus_ha_oe(bus_ha_oe), .bus_ale(bus_ale),
      .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n)
   );

   task automatic chk_eq(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic run_xfer(input logic [15:0] a, input logic we,
                           input logic [7:0] wd, input logic [7:0] seed,
                           input bit hold, input int chg_wlo);
      o_lat = 0; o_ale = 0; o_rd = 0; o_wr = 0; o_wbad = 0; o_rbad = 0;
      o_oe = 0; o_post = 0; o_haoe = 0; o_aaddr = '0; o_ahi = '0;
      @(negedge clk);
      req_addr = a; req_we = we; req_wdata = wd; req_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      if (!hold) req_valid = 1'b0;
      if (chg_wlo >= 0) cfg_wait_lo = 2'(chg_wlo);
      for (int n = 1; n <= 40; n++) begin
         if (bus_ale) begin
            o_ale++; o_aaddr = bus_ad_out; o_ahi = bus_ha_out;
            if (!bus_ad_oe) o_wbad++;
         end
         if (bus_ad_oe) o_oe++;
         if (bus_ha_oe != 8'h00) o_haoe++;
         if (!bus_rd_n) begin
            if (bus_ad_oe) o_rbad++;
            bus_ad_in = seed + 8'(o_rd);
            o_rd++;
         end
         if (!bus_wr_n) begin
            o_wr++;
            if (!bus_ad_oe || bus_ad_out != wd) o_wbad++;
         end
         if (rsp_ready) begin
            o_lat = n;
            break;
         end
         @(posedge clk);
         @(negedge clk);
      end
      if (hold) begin
         @(posedge clk);
         @(negedge clk);
         if (bus_ale) o_post++;
         req_valid = 1'b0;
      end
      for (int k = 0; k < 3; k++) begin
         @(posedge clk);
         @(negedge clk);
         if (bus_ale) o_post++;
      end
   endtask

   initial begin
      #(HALF * 2 * 100000);
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      // R1: state while in reset and just after release
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk_eq("R1 ale in reset", int'(bus_ale), 0);
      chk_eq("R1 rd_n in reset", int'(bus_rd_n), 1);
      chk_eq("R1 wr_n in reset", int'(bus_wr_n), 1);
      chk_eq("R1 ad_oe in reset", int'(bus_ad_oe), 0);
      chk_eq("R1 ready in reset", int'(rsp_ready), 0);
      rst_n = 1'b1;
      @(posedge clk);
      @(negedge clk);
      chk_eq("R1 ready after reset", int'(rsp_ready), 0);
      chk_eq("R1 strobes after reset", int'({bus_rd_n, bus_wr_n}), 3);

      // table walk: R2 R3 R4 R5 R6 R7 R8 R11
      cfg_en = 1'b1;
      cfg_hi_bits = 4'd8;
      for (int i = 0; i < NV; i++) begin
         logic [7:0] wd;
         logic [7:0] seed;
         int exp_lat;
         cfg_sector_lim = VECS[i].lim;
         cfg_wait_lo = VECS[i].wlo;
         cfg_wait_hi = VECS[i].whi;
         wd = 8'hA0 + 8'(i);
         seed = 8'h30 + 8'(i * 4);
         run_xfer(VECS[i].addr, VECS[i].we, wd, seed, 1'b0, -1);
         exp_lat = (VECS[i].strb == 0) ? 3 : int'(VECS[i].strb) + 2;
         chk_eq("R3 one ale pulse", o_ale, 1);
         chk_eq("R3 low address at ale", int'(o_aaddr), int'(VECS[i].addr[7:0]));
         chk_eq("R11 high address at ale", int'(o_ahi), int'(VECS[i].addr[15:8]));
         chk_eq("R8 ready latency", o_lat, exp_lat);
         if (VECS[i].we) begin
            chk_eq("R5 R4 R2 write strobe cycles", o_wr, int'(VECS[i].strb));
            chk_eq("R5 no read strobe on write", o_rd, 0);
            chk_eq("R6 write data drive", o_wbad, 0);
         end else begin
            chk_eq("R5 R4 R2 read strobe cycles", o_rd, int'(VECS[i].strb));
            chk_eq("R5 no write strobe on read", o_wr, 0);
            chk_eq("R7 released during read", o_rbad, 0);
            if (VECS[i].strb != 0)
               chk_eq("R7 read data from last cycle", int'(rsp_rdata),
                      int'(seed + 8'(VECS[i].strb) - 8'd1));
         end
      end

      // R9: request held high through the ready cycle
      cfg_sector_lim = 3'd0; cfg_wait_lo = 2'd1;
      run_xfer(16'h5000, 1'b1, 8'h5C, 8'h00, 1'b1, -1);
      chk_eq("R9 single ale while held", o_ale, 1);
      chk_eq("R9 single strobe window", o_wr, 2);
      chk_eq("R9 no access after ready", o_post, 0);

      // R12: wait setting changed after acceptance
      cfg_wait_lo = 2'd0;
      run_xfer(16'h9000, 1'b0, 8'h00, 8'h70, 1'b0, 3);
      chk_eq("R12 strobe length captured", o_rd, 1);
      chk_eq("R12 latency captured", o_lat, 3);
      chk_eq("R12 read data", int'(rsp_rdata), 8'h70);

      // R11: high address line enables
      cfg_hi_bits = 4'd3;
      @(negedge clk);
      chk_eq("R11 three lines", int'(bus_ha_oe), 8'h07);
      cfg_hi_bits = 4'd0;
      @(negedge clk);
      chk_eq("R11 no lines", int'(bus_ha_oe), 0);
      cfg_hi_bits = 4'd8;
      @(negedge clk);
      chk_eq("R11 all lines", int'(bus_ha_oe), 8'hFF);

      // R10: interface disabled
      cfg_en = 1'b0;
      cfg_wait_lo = 2'd3;
      run_xfer(16'h8000, 1'b0, 8'h00, 8'h11, 1'b0, -1);
      chk_eq("R10 ready next cycle", o_lat, 1);
      chk_eq("R10 no ale", o_ale, 0);
      chk_eq("R10 no strobe", o_rd + o_wr, 0);
      chk_eq("R10 ad not driven", o_oe, 0);
      chk_eq("R10 high lines not driven", o_haoe, 0);
      run_xfer(16'hC000, 1'b1, 8'h22, 8'h00, 1'b0, -1);
      chk_eq("R10 write ready next cycle", o_lat, 1);
      chk_eq("R10 write no strobe", o_wr, 0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule